// File: doc/BRIEF.md
# Sequential Instruction Prefetch Queue

This block keeps the execute stage supplied with instruction words by reading them from memory ahead of use. It holds a next-fetch address that assumes straight-line flow: every read targets the word after the previous one. Fetched words, each with the address it came from, wait in a small FIFO until the execute stage takes them through a valid/ready handshake. Memory reads go out one at a time through a request/acknowledge port, so fetching overlaps with whatever the execute stage is doing.

The CPU tells the queue when it writes a state register that can change program flow or address mapping. There are four such sources: the status word, the cache control register, the program counter (which covers taken branches) and the memory-management registers. Each one discards the queued words and restarts fetching at a supplied PC. A write to an ordinary device register outside the CPU has no flush input. Words already queued are still delivered even if that write remapped memory. A restart target with bit 0 set is not fetched and raises an odd-address fault instead.

Top module: `seq_prefetch_queue`

## Requirements
- R1: While reset is held, `memReq`, `instValid` and `oddFault` are 0. After reset, the first word delivered is the one at address `RESET_PC` (default 0).
- R2: Addresses are byte addresses and words are 16 bits. Each fetch address is the previous fetch address plus 2, wrapping modulo 2^16. Words leave the queue in fetch order, each with the address it was read from.
- R3: The queue holds at most `DEPTH` words (default 2), and a new read is issued only while an entry is free. A request holds `memReq` high with a stable `memAddr` until the single cycle in which `memAck` is high. `memData` is taken in that cycle.
- R4: A pulse on `flushStatus` empties the queue. The next word delivered is the one at `newPc`.
- R5: A pulse on `flushCache` empties the queue. The next word delivered is the one at `newPc`.
- R6: A pulse on `flushPc` empties the queue. The next word delivered is the one at `newPc`.
- R7: A pulse on `flushMmu` empties the queue. The next word delivered is the one at `newPc`.
- R8: A read still in flight when a flush occurs runs to its acknowledge, and its data is thrown away. `instValid` is 0 in the cycle after any flush, and no word fetched before the flush is ever delivered after it.
- R9: A flush whose `newPc` has bit 0 set drives `oddFault` to 1 and starts no fetch. `instValid` stays 0 until a flush with an even target clears `oddFault` and resumes fetching.
- R10: With no flush input, words already in the queue are delivered with the data read at fetch time, even if memory contents change afterwards.
- R11: A word is removed only in a cycle with `instValid` and `instReady` both high. While `instValid` is high and `instReady` is low, `instData` and `instAddr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memReq | output | 1 | Read request, held until acknowledged |
| memAddr | output | 16 | Byte address of the requested word |
| memAck | input | 1 | One-cycle acknowledge; `memData` valid in this cycle |
| memData | input | 16 | Read data |
| instValid | output | 1 | Head word is available |
| instReady | input | 1 | Execute stage takes the head word |
| instData | output | 16 | Head instruction word |
| instAddr | output | 16 | Address of the head word |
| flushStatus | input | 1 | Status word was written |
| flushCache | input | 1 | Cache control register was written |
| flushPc | input | 1 | Program counter was written or a branch was taken |
| flushMmu | input | 1 | A memory-management register was written |
| newPc | input | 16 | Restart address, used in the cycle of a flush |
| oddFault | output | 1 | Last restart target was odd; fetching is stopped |

## Verification
The assertions assume that memory raises `memAck` only while `memReq` is high, and for exactly one cycle per request. They also assume that `RESET_PC` is even and that `newPc` is examined only in flush cycles. The bench's memory responder acknowledges only a pending request, after a chosen latency of zero to three cycles, and drops `memAck` on the following cycle. Flushes are single-cycle pulses with `newPc` set alongside. The sweep combines every latency with several consumer ready patterns and all four flush causes. Directed cases place a flush inside a slow read, change memory contents under a full queue, and use odd restart targets.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  // Strobes from control to datapath, one per datapath action
  typedef struct packed {
    logic issue;  // capture next-fetch address as request address, advance
    logic push;   // write acknowledged word into the queue
    logic pop;    // remove head word
    logic clear;  // flush: empty queue, reload next-fetch address
  } pfqStrobe_t;

endpackage

// File: rtl/pfq_datapath.sv
module pfq_datapath
  import pfq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfqStrobe_t        strb,
  input  logic [ADDR_W-1:0] newPc,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] headData,
  output logic [ADDR_W-1:0] headAddr,
  output logic [CNT_W-1:0]  count
);

  localparam int WORD_BYTES = DATA_W / 8;

  logic [ADDR_W-1:0] nextPc;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] entryData [DEPTH];
  logic [ADDR_W-1:0] entryAddr [DEPTH];

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  // Next-fetch address and the address of the outstanding request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc  <= RESET_PC;
      reqAddr <= RESET_PC;
    end else if (strb.clear) begin
      nextPc  <= newPc;
    end else if (strb.issue) begin
      reqAddr <= nextPc;
      nextPc  <= nextPc + ADDR_W'(WORD_BYTES);
    end
  end

  // Queue entries
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryData[e] <= '0;
        entryAddr[e] <= '0;
      end else if (strb.push && !strb.clear && wrPtr == PTR_W'(e)) begin
        entryData[e] <= memData;
        entryAddr[e] <= reqAddr;
      end
    end
  end

  // Pointers and occupancy
  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= ptrInc(wrPtr);
      if (strb.pop)  rdPtr <= ptrInc(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign headData = entryData[rdPtr];
  assign headAddr = entryAddr[rdPtr];

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R3
  push_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (count < CNT_W'(DEPTH)) || strb.pop);

  // R2
  issue_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue && !strb.clear |=> nextPc == reqAddr + ADDR_W'(WORD_BYTES));

endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
  import pfq_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flushStatus,
  input  logic             flushCache,
  input  logic             flushPc,
  input  logic             flushMmu,
  input  logic             newPcOdd,
  input  logic             memAck,
  input  logic             instReady,
  input  logic [CNT_W-1:0] count,
  output pfqStrobe_t       strb,
  output logic             memReq,
  output logic             instValid,
  output logic             oddFault
);

  logic flushAny;
  logic reqActive;
  logic discard;
  logic faulted;
  logic ackNow;

  assign flushAny  = flushStatus | flushCache | flushPc | flushMmu;
  assign ackNow    = reqActive & memAck;
  assign instValid = (count != '0);

  always_comb begin
    strb.clear = flushAny;
    strb.push  = ackNow & ~discard & ~flushAny;
    strb.pop   = instValid & instReady & ~flushAny;
    strb.issue = ~flushAny & ~reqActive & ~faulted & (count < CNT_W'(DEPTH));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqActive <= 1'b0;
      discard   <= 1'b0;
      faulted   <= 1'b0;
    end else begin
      if (strb.issue)  reqActive <= 1'b1;
      else if (ackNow) reqActive <= 1'b0;

      // a read caught by a flush finishes, but its word is dropped
      if (ackNow)                     discard <= 1'b0;
      else if (reqActive && flushAny) discard <= 1'b1;

      if (flushAny) faulted <= newPcOdd;
    end
  end

  assign memReq   = reqActive;
  assign oddFault = faulted;

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushAny |=> !instValid);

  // R9
  fault_noreq_chk: assert property (@(posedge clk) disable iff (!rstN)
    oddFault && !memReq |=> !memReq);

  // R3
  issue_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> $past(count) < CNT_W'(DEPTH));

  // R11
  hold_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    instValid && !instReady && !flushAny |=> instValid);

endmodule

// File: rtl/seq_prefetch_queue.sv
module seq_prefetch_queue
  import pfq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memData,
  output logic              instValid,
  input  logic              instReady,
  output logic [DATA_W-1:0] instData,
  output logic [ADDR_W-1:0] instAddr,
  input  logic              flushStatus,
  input  logic              flushCache,
  input  logic              flushPc,
  input  logic              flushMmu,
  input  logic [ADDR_W-1:0] newPc,
  output logic              oddFault
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  pfqStrobe_t       strb;
  logic [CNT_W-1:0] count;

  pfq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .flushStatus (flushStatus),
    .flushCache  (flushCache),
    .flushPc     (flushPc),
    .flushMmu    (flushMmu),
    .newPcOdd    (newPc[0]),
    .memAck      (memAck),
    .instReady   (instReady),
    .count       (count),
    .strb        (strb),
    .memReq      (memReq),
    .instValid   (instValid),
    .oddFault    (oddFault)
  );

  pfq_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .DEPTH    (DEPTH),
    .RESET_PC (RESET_PC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .newPc    (newPc),
    .memData  (memData),
    .reqAddr  (memAddr),
    .headData (instData),
    .headAddr (instAddr),
    .count    (count)
  );

  logic anyFlush;
  assign anyFlush = flushStatus | flushCache | flushPc | flushMmu;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr));

  // R2
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !memAddr[0]);

  // R11
  stable_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    instValid && !instReady && !anyFlush |=> $stable(instData) && $stable(instAddr));

endmodule

// File: tb/seq_prefetch_queue_tb.sv
module seq_prefetch_queue_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memReq, memAck = 1'b0;
  logic [15:0] memAddr, memData = '0;
  logic        instValid, instReady = 1'b0;
  logic [15:0] instData, instAddr;
  logic        flushStatus = 0, flushCache = 0, flushPc = 0, flushMmu = 0;
  logic [15:0] newPc = '0;
  logic        oddFault;

  int vectors = 0;
  int fails = 0;
  int lat = 0;
  int readyPat = 0;
  logic [15:0] bank = 16'h0000;

  always #10 clk = ~clk;

  seq_prefetch_queue u_dut (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memAddr(memAddr),
    .memAck(memAck), .memData(memData), .instValid(instValid),
    .instReady(instReady), .instData(instData), .instAddr(instAddr),
    .flushStatus(flushStatus), .flushCache(flushCache), .flushPc(flushPc),
    .flushMmu(flushMmu), .newPc(newPc), .oddFault(oddFault)
  );

  function automatic logic [15:0] memFn(input logic [15:0] a, input logic [15:0] b);
    return (a * 16'd3) ^ b ^ 16'h5A00;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  // memory responder: acknowledges a pending request after lat cycles
  initial begin
    int waitCnt;
    waitCnt = 0;
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck  = 1'b0;
        waitCnt = 0;
      end else if (memReq && rstN) begin
        if (waitCnt >= lat) begin
          memAck  = 1'b1;
          memData = memFn(memAddr, bank);
        end else begin
          waitCnt++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  // one-cycle flush pulse; cause 0 status, 1 cache, 2 pc, 3 mmu
  task automatic doFlush(input int cause, input logic [15:0] pc);
    instReady   = 1'b0;
    newPc       = pc;
    flushStatus = (cause == 0);
    flushCache  = (cause == 1);
    flushPc     = (cause == 2);
    flushMmu    = (cause == 3);
    @(negedge clk);
    flushStatus = 0; flushCache = 0; flushPc = 0; flushMmu = 0;
    // R8: queue empty right after the flush
    chk(instValid == 1'b0, "R8 empty after flush", {31'd0, instValid}, 32'd0);
  endtask

  // take cnt words, expecting start, start+2, ...
  task automatic consume(input int cnt, input logic [15:0] start, input string req);
    int got;
    int cyc;
    logic [15:0] expA;
    got = 0;
    cyc = 0;
    while (got < cnt && cyc < 400) begin
      instReady = (readyPat == 0) ? 1'b1 : ((cyc % (readyPat + 1)) == 0);
      if (instValid && instReady) begin
        expA = start + 16'(2 * got);
        chk(instAddr == expA, req, {16'd0, instAddr}, {16'd0, expA});
        chk(instData == memFn(expA, bank), req, {16'd0, instData},
            {16'd0, memFn(expA, bank)});
        got++;
      end
      @(negedge clk);
      cyc++;
    end
    instReady = 1'b0;
    chk(got == cnt, {req, " word count"}, got, cnt);
  endtask

  initial begin
    logic [15:0] held;
    logic [15:0] oldBank;
    string causeTag [4];
    causeTag[0] = "R4 status flush";
    causeTag[1] = "R5 cache flush";
    causeTag[2] = "R6 pc flush";
    causeTag[3] = "R7 mmu flush";

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(memReq == 0 && instValid == 0 && oddFault == 0, "R1 reset outputs",
        {29'd0, memReq, instValid, oddFault}, 32'd0);
    rstN = 1'b1;
    // R1/R2 first words from RESET_PC
    consume(4, 16'h0000, "R1 R2 start at reset pc");

    // sweep: latency x ready pattern x flush cause
    for (int l = 0; l < 4; l++) begin
      for (int p = 0; p < 4; p++) begin
        for (int c = 0; c < 4; c++) begin
          logic [15:0] start;
          lat = l;
          readyPat = p;
          start = 16'h1000 + 16'((l * 16 + p * 4 + c) * 64);
          doFlush(c, start);
          consume(5, start, causeTag[c]);
        end
      end
    end

    // R2 address wrap
    lat = 1; readyPat = 0;
    doFlush(2, 16'hFFFA);
    consume(6, 16'hFFFA, "R2 wrap");

    // R8 flush while a slow read is in flight
    for (int c = 0; c < 4; c++) begin
      lat = 3; readyPat = 0;
      doFlush(2, 16'h3000);
      do begin
        @(negedge clk); #1;
      end while (!(memReq && !memAck));
      @(negedge clk);
      doFlush(c, 16'h4000 + 16'(c * 256));
      consume(4, 16'h4000 + 16'(c * 256), "R8 in-flight discard");
    end

    // R3/R10/R11 full queue, memory changes underneath
    lat = 0; readyPat = 0;
    doFlush(1, 16'h5000);
    repeat (20) @(negedge clk);
    chk(memReq == 0, "R3 no request when full", {31'd0, memReq}, 32'd0);
    chk(instValid == 1, "R3 queue holds words", {31'd0, instValid}, 32'd1);
    held = instData;
    repeat (3) @(negedge clk);
    chk(instData == held && instAddr == 16'h5000, "R11 head stable",
        {instAddr, instData}, {16'h5000, held});
    oldBank = bank;
    bank = 16'h3C3C;
    instReady = 1'b1;
    for (int k = 0; k < 2; k++) begin
      chk(instValid && instAddr == 16'h5000 + 16'(2 * k) &&
          instData == memFn(16'h5000 + 16'(2 * k), oldBank),
          "R10 stale words delivered", {instAddr, instData},
          {16'h5000 + 16'(2 * k), memFn(16'h5000 + 16'(2 * k), oldBank)});
      @(negedge clk);
    end
    instReady = 1'b0;
    consume(1, 16'h5004, "R10 later fetch sees new contents");

    // R9 odd restart target
    for (int c = 0; c < 4; c++) begin
      lat = c; readyPat = 0;
      doFlush(c, 16'h0103 + 16'(c * 16));
      repeat (10) @(negedge clk);
      chk(oddFault == 1 && memReq == 0 && instValid == 0, "R9 odd target faults",
          {29'd0, oddFault, memReq, instValid}, 32'd4);
      doFlush(3 - c, 16'h0200 + 16'(c * 16));
      chk(oddFault == 0, "R9 even target clears", {31'd0, oddFault}, 32'd0);
      consume(3, 16'h0200 + 16'(c * 16), "R9 resume after fault");
    end

    summary();
    $finish;
  end

endmodule